// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block is the digital front end of a two-channel parallel-input converter. A host drives a code onto a parallel bus and pulls chip select low. A channel address line steers the code into one of two first-stage registers. Each channel then has a second-stage register that holds the code the converter actually presents. A per-channel active-low load strobe opens the second stage. While the strobe is low, the second stage follows the first stage. When the strobe goes high, the second stage keeps the last value it took.

Because the stages are separate, the host can load both first stages one after the other and then lower both strobes together, so that both channel codes change in the same cycle. An asynchronous active-low clear sets every register to zero scale. An active-low shutdown input marks both outputs as open circuit, but register loading carries on as normal while it is asserted.

The strobes are level-sensitive. In this design that transparency is modelled on a system clock: every control input is sampled on the rising clock edge. The code width is a parameter, 12 bits by default and 10 bits for the reduced variant. The control protocol is the same for both widths.

Top module: `dual_dac_frontend`

## Requirements
- R1: With `cs_n` low at a clock edge, `din` is stored in channel A's first stage when `sel_a` is 1 and in channel B's first stage when `sel_a` is 0. The first stage of the channel that is not addressed keeps its value.
- R2: While a channel's load strobe is high, that channel's output code keeps its value across clock edges, even while the channel's first stage is being written.
- R3: The output code keeps the value it took in the last edge with the strobe low. A write in the same edge that the strobe returns high does not reach the output.
- R4: With both strobes low and `cs_n` high, both output codes take their first-stage values at the same clock edge.
- R5: A write with the addressed channel's strobe also low appears on that channel's output code one clock edge after the write edge.
- R6: While `cs_n` is high, neither first stage changes, whatever `din` carries.
- R7: When `clr_n` goes low, all four registers are cleared to code 0 at once, without waiting for a clock edge, and both output-enable flags go to 0. After `clr_n` is released, the codes stay at 0 until new data is loaded.
- R8: `shdn_n` has no effect on writes to either stage. One edge after `shdn_n` is sampled low, both output-enable flags are 0.
- R9: One edge after `shdn_n` is sampled high again, both output-enable flags are 1, and each output shows the most recent code held in its second stage, including codes loaded during shutdown.
- R10: The code width is the parameter `RES_BITS` (12 by default, 10 for the reduced variant). The all-ones code passes through both stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear to zero scale |
| cs_n | input | 1 | Active-low chip select; enables a first-stage write |
| sel_a | input | 1 | Channel address: 1 selects A, 0 selects B |
| ld_a_n | input | 1 | Active-low level strobe for channel A's second stage |
| ld_b_n | input | 1 | Active-low level strobe for channel B's second stage |
| shdn_n | input | 1 | Active-low shutdown; only disables the output drive |
| din | input | RES_BITS | Parallel code bus |
| code_a | output | RES_BITS | Channel A second-stage code |
| code_b | output | RES_BITS | Channel B second-stage code |
| oe_a | output | 1 | Channel A output driven (1) or open circuit (0) |
| oe_b | output | 1 | Channel B output driven (1) or open circuit (0) |

## Verification
Two things can land in the same clock edge: a first-stage write and the second stage of that channel being open. This shows up in two cases. When the strobe is held low through the write, the new code must reach the output at the very next edge. When the strobe rises in the same edge as a write, the output must keep the code it had before that write. The bench provokes each case by setting chip select, address and strobe together before a single edge. It then judges the output code after that edge, and again after a later edge that opens the strobe on its own. A shutdown assertion overlapping a write-through is also exercised, to show that the code moves while the enable flag stays low.

// File: rtl/ddf_pkg.sv
package ddf_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;

  typedef enum logic {
    ADDR_B = 1'b0,
    ADDR_A = 1'b1
  } chan_addr_e;

  function automatic logic addr_hits(input logic sel_a, input int unsigned ch);
    return (ch == CH_A) ? (sel_a == ADDR_A) : (sel_a == ADDR_B);
  endfunction
endpackage

// File: rtl/ddf_input_stage.sv
module ddf_input_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  // Next-state value is exported so the second stage can pass a write
  // through in the same edge.
  always_comb q_next = wr_en ? din : q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/ddf_hold_stage.sv
module ddf_hold_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         follow_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        q <= '0;
    else if (!follow_n) q <= src;
  end
endmodule

// File: rtl/ddf_drive_flag.sv
module ddf_drive_flag (
  input  logic clk,
  input  logic clr_n,
  input  logic awake_n,
  output logic en
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) en <= 1'b0;
    else        en <= awake_n;
  end
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic                cs_n,
  input  logic                sel_a,
  input  logic                ld_a_n,
  input  logic                ld_b_n,
  input  logic                shdn_n,
  input  logic [RES_BITS-1:0] din,
  output logic [RES_BITS-1:0] code_a,
  output logic [RES_BITS-1:0] code_b,
  output logic                oe_a,
  output logic                oe_b
);
  import ddf_pkg::*;

  localparam int unsigned W = RES_BITS;

  logic [W-1:0]      in_q    [NUM_CH];
  logic [W-1:0]      in_next [NUM_CH];
  logic [W-1:0]      out_q   [NUM_CH];
  logic [NUM_CH-1:0] ld_n;
  logic [NUM_CH-1:0] drv;

  always_comb begin
    ld_n[CH_A] = ld_a_n;
    ld_n[CH_B] = ld_b_n;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic wr_en;
    always_comb wr_en = !cs_n && addr_hits(sel_a, ch);

    ddf_input_stage #(.W(W)) u_in (
      .clk    (clk),
      .clr_n  (clr_n),
      .wr_en  (wr_en),
      .din    (din),
      .q      (in_q[ch]),
      .q_next (in_next[ch])
    );

    ddf_hold_stage #(.W(W)) u_hold (
      .clk      (clk),
      .clr_n    (clr_n),
      .follow_n (ld_n[ch]),
      .src      (in_next[ch]),
      .q        (out_q[ch])
    );

    ddf_drive_flag u_drv (
      .clk     (clk),
      .clr_n   (clr_n),
      .awake_n (shdn_n),
      .en      (drv[ch])
    );
  end

  assign code_a = out_q[CH_A];
  assign code_b = out_q[CH_B];
  assign oe_a   = drv[CH_A];
  assign oe_b   = drv[CH_B];
endmodule

// File: rtl/ddf_checker.sv
module ddf_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         clr_n,
  input logic         cs_n,
  input logic         sel_a,
  input logic         ld_a_n,
  input logic         ld_b_n,
  input logic         shdn_n,
  input logic [W-1:0] din,
  input logic [W-1:0] code_a,
  input logic [W-1:0] code_b,
  input logic         oe_a,
  input logic         oe_b,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b
);
  assert_unaddressed_b_keeps_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && sel_a) |=> (in_b == $past(in_b)));
  assert_unaddressed_a_keeps_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !sel_a) |=> (in_a == $past(in_a)));
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!clr_n)
    ld_a_n |=> (code_a == $past(code_a)));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!clr_n)
    ld_b_n |=> (code_b == $past(code_b)));
  assert_shared_strobe_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n && !ld_a_n && !ld_b_n) |=> (code_a == $past(in_a) && code_b == $past(in_b)));
  assert_through_a_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && sel_a && !ld_a_n) |=> (code_a == $past(din)));
  assert_through_b_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !sel_a && !ld_b_n) |=> (code_b == $past(din)));
  assert_no_select_R6: assert property (@(posedge clk) disable iff (!clr_n)
    cs_n |=> ($stable(in_a) && $stable(in_b)));
  assert_off_R8: assert property (@(posedge clk) disable iff (!clr_n)
    !shdn_n |=> (!oe_a && !oe_b));
  assert_on_R9: assert property (@(posedge clk) disable iff (!clr_n)
    shdn_n |=> (oe_a && oe_b));

  always @(posedge clk) begin
    if (!clr_n) begin
      assert_clear_R7: assert (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0
                               && !oe_a && !oe_b);
    end
  end
endmodule

bind dual_dac_frontend ddf_checker #(.W(RES_BITS)) u_ddf_checker (
  .clk    (clk),
  .clr_n  (clr_n),
  .cs_n   (cs_n),
  .sel_a  (sel_a),
  .ld_a_n (ld_a_n),
  .ld_b_n (ld_b_n),
  .shdn_n (shdn_n),
  .din    (din),
  .code_a (code_a),
  .code_b (code_b),
  .oe_a   (oe_a),
  .oe_b   (oe_b),
  .in_a   (in_q[0]),
  .in_b   (in_q[1])
);

// File: tb/test_dual_dac_frontend.sv
module test_dual_dac_frontend;
  localparam int unsigned W = 12;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic         cs_n = 1'b1;
  logic         sel_a = 1'b0;
  logic         ld_a_n = 1'b1;
  logic         ld_b_n = 1'b1;
  logic         shdn_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] code_a, code_b;
  logic         oe_a, oe_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dual_dac_frontend #(.RES_BITS(W)) i_dual_dac_frontend (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sel_a(sel_a),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .shdn_n(shdn_n), .din(din),
    .code_a(code_a), .code_b(code_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; one rising edge follows; sample at next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input logic cs, input logic sa, input logic la, input logic lb,
                       input logic [W-1:0] d);
    cs_n = cs; sel_a = sa; ld_a_n = la; ld_b_n = lb; din = d;
  endtask

  task automatic t_reset();
    #2 clr_n = 1'b0;
    step(); step();
    check("R7 code_a in clear", code_a, 12'h000);
    check("R7 code_b in clear", code_b, 12'h000);
    check("R7 oe_a in clear", {11'd0, oe_a}, 12'h000);
    clr_n = 1'b1;
    step();
    check("R7 code_a after release", code_a, 12'h000);
    check("R9 oe_a awake", {11'd0, oe_a}, 12'h001);
    check("R9 oe_b awake", {11'd0, oe_b}, 12'h001);
  endtask

  task automatic t_shared_strobe();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hABC); step();
    check("R2 code_a held during write", code_a, 12'h000);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'h123); step();
    check("R2 code_b held during write", code_b, 12'h000);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000); step();
    check("R4 code_a shared update", code_a, 12'hABC);
    check("R4 code_b shared update", code_b, 12'h123);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h000); step();
  endtask

  task automatic t_write_through();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 12'h456); step();
    check("R5 code_a write-through", code_a, 12'h456);
    check("R1 code_b untouched by A write", code_b, 12'h123);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h789); step();
    check("R3 code_a kept at strobe release", code_a, 12'h456);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h000); step();
    check("R3 code_a picks later write", code_a, 12'h789);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 12'h0F0); step();
    check("R5 code_b write-through", code_b, 12'h0F0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h000); step();
  endtask

  task automatic t_no_select();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 12'hFFF); step(); step();
    check("R6 code_a with cs high", code_a, 12'h789);
    check("R6 code_b with cs high", code_b, 12'h0F0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h333); step();
    check("R1 code_a after B write", code_a, 12'h789);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h000); step();
  endtask

  task automatic t_clear_mid();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h321); step();
    #2 clr_n = 1'b0;
    #1;
    check("R7 code_a cleared without edge", code_a, 12'h000);
    check("R7 code_b cleared without edge", code_b, 12'h000);
    step();
    clr_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000); step();
    check("R7 code_a first stage cleared", code_a, 12'h000);
    check("R7 code_b first stage cleared", code_b, 12'h000);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h000); step();
  endtask

  task automatic t_shutdown();
    shdn_n = 1'b0; step();
    check("R8 oe_a off", {11'd0, oe_a}, 12'h000);
    check("R8 oe_b off", {11'd0, oe_b}, 12'h000);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 12'h5A5); step();
    check("R8 code_a loads in shutdown", code_a, 12'h5A5);
    check("R8 oe_a still off", {11'd0, oe_a}, 12'h000);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF); step();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 12'h000); step();
    check("R10 all-ones code_b", code_b, 12'hFFF);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h000);
    shdn_n = 1'b1; step();
    check("R9 oe_a back on", {11'd0, oe_a}, 12'h001);
    check("R9 code_a resumes", code_a, 12'h5A5);
    check("R9 code_b resumes", code_b, 12'hFFF);
  endtask

  initial begin
    t_reset();
    t_shared_strobe();
    t_write_through();
    t_no_select();
    t_clear_mid();
    t_shutdown();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule